// File: doc/BRIEF.md
# Four-Phase Spread-Duty PWM Generator

This block turns a 10-bit duty code into a pulse train. Each conversion period is split into four equal windows. Each window opens with its own high pulse. Because the high time is spread across four pulses instead of one, a simple RC filter after the pin sees a ripple at four times the period rate. The total high time in one period is the duty code plus four input ticks. A 2-bit select sets the length of one tick.

Software writes the duty code through a plain write-strobe port. The low eight bits are written first and are held in a staging byte. Writing the top two bits then forms the complete pending code. The code reaches the waveform only at the next period boundary, so no period ever carries a mix of two codes. A single enable gates the block. While the enable is clear, the pin is low and all counters and stored codes are held at zero.

Top module: `qpwm_top`

## Requirements
- R1: While `rst` is high the output `pwm_o` is low, and after reset the active duty code is zero (a period then holds 4 high ticks).
- R2: One PWM tick lasts 1, 2, 4 or 8 clock cycles for `clk_sel` = 0, 1, 2 or 3.
- R3: A conversion period lasts 1024 ticks and is split into four windows of 256 ticks. Each window begins with a rising edge of `pwm_o` whenever no window is fully high.
- R4: The number of high ticks in one period equals min(D + 4, 1024), where D is the active 10-bit code.
- R5: Window k (k = 0..3) is high from its start for D[9:2] + 1 ticks, plus one more tick when k < D[1:0], capped at 256 ticks.
- R6: A write with `wr_addr` = 0 stores `wr_data[7:0]` as the low byte of the code. A write with `wr_addr` = 1 forms the pending code {`wr_data[1:0]`, stored low byte}. A low byte written after the upper write is therefore not part of that code.
- R7: A write of the low byte alone leaves the waveform unchanged.
- R8: A pending code becomes active only at the start of a new period. The period in which the upper byte is written keeps the old code for its full length.
- R9: While `out_en` is low, `pwm_o` is low from the next cycle on, and the counters, staging byte, pending code and active code are cleared. Writes in that state are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | Write target: 0 = low byte, 1 = upper bits (commit) |
| wr_data | input | 8 | Write data |
| clk_sel | input | 2 | Tick length select: 2^clk_sel clock cycles |
| out_en | input | 1 | Output and function enable |
| pwm_o | output | 1 | PWM output |

## Verification
Some rules are checked by assertions on every cycle. The pin stays low after the enable drops, and all stored codes are cleared. The period counter holds still between ticks. The prescaler never fires on two adjacent cycles when the tick is longer than one clock. The active code changes only on a period wrap or while the block is disabled. Other behaviour is visible only over whole periods, so the bench scenarios cover it. These are the per-window high counts, the total of D + 4 ticks, the four rising edges spaced one window apart, and the one-period delay before a new code takes effect. They also cover the two cases that must leave the waveform as it was: a lone low-byte write, and writes made while disabled.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    localparam int DUTY_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int HI_W    = DUTY_W - BYTE_W;
    localparam int SEL_W   = 2;
    localparam int QTR_W   = 2;
    localparam int POS_W   = DUTY_W - QTR_W;
    localparam int CNT_W   = DUTY_W;
    localparam int PRE_W   = (1 << SEL_W) - 1;
    localparam int THR_W   = POS_W + 1;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [THR_W-1:0]  thr_t;

    typedef enum logic {
        WR_LO = 1'b0,
        WR_HI = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic [QTR_W-1:0] qtr;
        logic [POS_W-1:0] pos;
    } slot_t;

    // High ticks of window q for code d: coarse part + 1, plus one
    // extra tick for the first d[1:0] windows.
    function automatic thr_t sub_threshold(duty_t d, logic [QTR_W-1:0] q);
        thr_t base;
        base = {1'b0, d[DUTY_W-1:QTR_W]} + thr_t'(1);
        if (q < d[QTR_W-1:0])
            base = base + thr_t'(1);
        return base;
    endfunction

endpackage

// File: rtl/qpwm_prescaler.sv
module qpwm_prescaler
    import qpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    assign mask = ~({PRE_W{1'b1}} << sel);
    assign tick = en && (pre == mask);

    always_ff @(posedge clk) begin
        if (rst || !en)
            pre <= '0;
        else if (tick)
            pre <= '0;
        else
            pre <= pre + PRE_W'(1);
    end

    // R2: a tick longer than one clock never fires on back-to-back cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0) |=> (!tick || sel == '0));

endmodule

// File: rtl/qpwm_data_latch.sv
module qpwm_data_latch
    import qpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              period_end,
    output duty_t             active
);

    logic [BYTE_W-1:0] lo_stage;
    duty_t             pending;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lo_stage <= '0;
            pending  <= '0;
            active   <= '0;
        end else begin
            if (wr_en && wr_target_e'(wr_addr) == WR_LO)
                lo_stage <= wr_data;
            if (wr_en && wr_target_e'(wr_addr) == WR_HI)
                pending <= {wr_data[HI_W-1:0], lo_stage};
            if (period_end)
                active <= pending;
        end
    end

    // R8: the active code moves only at a period wrap (or on disable)
    a_r8_update_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> ($past(period_end) || !$past(en)));

    // R9: disable clears every stored code
    a_r9_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (active == '0 && pending == '0 && lo_stage == '0));

endmodule

// File: rtl/qpwm_subpulse_gen.sv
module qpwm_subpulse_gen
    import qpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  tick,
    input  duty_t active,
    output logic  period_end,
    output logic  pwm_o
);

    logic [CNT_W-1:0] cnt;
    slot_t            slot;
    thr_t             thr;

    assign slot       = slot_t'(cnt);
    assign thr        = sub_threshold(active, slot.qtr);
    assign period_end = tick && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            pwm_o <= 1'b0;
        end else begin
            if (tick)
                cnt <= cnt + CNT_W'(1);
            pwm_o <= ({1'b0, slot.pos} < thr);
        end
    end

    // R2: the period counter advances only on a tick
    a_r2_count_on_tick: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> (cnt == $past(cnt)));

    // R9: output low in the cycle after the enable is seen low
    a_r9_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_o);

    // R1: output low while reset is applied
    a_r1_low_in_reset: assert property (@(posedge clk)
        rst |=> (!pwm_o && cnt == '0));

endmodule

// File: rtl/qpwm_top.sv
module qpwm_top
    import qpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              out_en,
    output logic              pwm_o
);

    logic  tick;
    logic  period_end;
    duty_t active;

    qpwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (out_en),
        .sel  (clk_sel),
        .tick (tick)
    );

    qpwm_data_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .en         (out_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .period_end (period_end),
        .active     (active)
    );

    qpwm_subpulse_gen u_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (out_en),
        .tick       (tick),
        .active     (active),
        .period_end (period_end),
        .pwm_o      (pwm_o)
    );

endmodule

// File: tb/qpwm_top_bench.sv
`timescale 1ns/1ps
module qpwm_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] clk_sel = 2'd0;
    logic       out_en = 1'b0;
    logic       pwm_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    qpwm_top u_qpwm_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_sel (clk_sel),
        .out_en  (out_en),
        .pwm_o   (pwm_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one write on the next posedge (called right after a negedge)
    task automatic put_write(input bit addr, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
    endtask

    task automatic end_write();
        wr_en = 1'b0;
    endtask

    // Disable, select the tick, then enable at a negedge. Sample i is taken
    // at the negedge after the i-th posedge of the first period.
    task automatic start_aligned(input int sel);
        @(negedge clk);
        out_en  = 1'b0;
        clk_sel = 2'(sel);
        repeat (2) @(negedge clk);
        out_en = 1'b1;
    endtask

    // Count high samples over one period; optional write of a full code
    task automatic run_period(input int sel, input bit do_wr, input int code,
                              input int wr_at, output int highs);
        int plen = 1024 << sel;
        highs = 0;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
            if (do_wr && i == wr_at)     put_write(1'b0, code[7:0]);
            if (do_wr && i == wr_at + 1) put_write(1'b1, {6'd0, code[9:8]});
            if (do_wr && i == wr_at + 2) end_write();
        end
    endtask

    // Main scenario: code loaded in period 0, measured window by window in period 1
    task automatic case_code(input int sel, input int code);
        int plen = 1024 << sel;
        int qlen = 256 << sel;
        int q_cnt [4];
        int exp_q [4];
        int total, edges, second_edge, dummy, exp_total;
        bit prev, all_short;
        start_aligned(sel);
        run_period(sel, 1'b1, code, 10, dummy);
        for (int k = 0; k < 4; k++) q_cnt[k] = 0;
        total = 0; edges = 0; second_edge = -1; prev = 1'b0;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            if (pwm_o) begin
                q_cnt[i / qlen]++;
                total++;
            end
            if (pwm_o && !prev) begin
                edges++;
                if (edges == 2) second_edge = i;
            end
            prev = pwm_o;
        end
        all_short = 1'b1;
        for (int k = 0; k < 4; k++) begin
            exp_q[k] = (code >> 2) + 1 + ((k < (code & 3)) ? 1 : 0);
            if (exp_q[k] > 256) exp_q[k] = 256;
            if (exp_q[k] == 256) all_short = 1'b0;
            check(q_cnt[k] == (exp_q[k] << sel), "R5 window high count", q_cnt[k], exp_q[k] << sel);
        end
        exp_total = code + 4;
        if (exp_total > 1024) exp_total = 1024;
        check(total == (exp_total << sel), "R4 period high total", total, exp_total << sel);
        if (all_short) begin
            check(edges == 4, "R3 four pulses per period", edges, 4);
            check(second_edge == qlen, "R2 window spacing in clocks", second_edge, qlen);
        end
    endtask

    task automatic case_reset();
        @(negedge clk);
        rst = 1'b1; out_en = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1 output low in reset", int'(pwm_o), 0);
        rst = 1'b0; out_en = 1'b0;
        @(negedge clk);
        begin
            int h;
            start_aligned(0);
            run_period(0, 1'b0, 0, 0, h);
            check(h == 4, "R1 zero code after reset", h, 4);
        end
    endtask

    // R8: upper write mid-period does not touch that period; R7: lone low write ignored
    task automatic case_update_and_lo_only();
        int h;
        start_aligned(0);
        run_period(0, 1'b1, 1023, 300, h);
        check(h == 4, "R8 old code kept for whole period", h, 4);
        run_period(0, 1'b0, 0, 0, h);
        check(h == 1024, "R8 new code at next period", h, 1024);
        @(negedge clk); put_write(1'b0, 8'h00);
        @(negedge clk); end_write();
        repeat (1024) @(negedge clk);
        run_period(0, 1'b0, 0, 0, h);
        check(h == 1024, "R7 low byte alone no effect", h, 1024);
    endtask

    // R6: low byte written after the upper write is not part of the code
    task automatic case_order();
        int h;
        start_aligned(0);
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            if (i == 20) put_write(1'b1, 8'h01);
            if (i == 21) put_write(1'b0, 8'h07);
            if (i == 22) end_write();
        end
        run_period(0, 1'b0, 0, 0, h);
        check(h == 260, "R6 upper write commits staged low byte", h, 260);
    endtask

    // R9: disable forces low, clears codes, drops writes
    task automatic case_disable();
        int h;
        start_aligned(0);
        run_period(0, 1'b1, 1023, 5, h);
        @(negedge clk);
        check(pwm_o == 1'b1, "R9 output high before disable", int'(pwm_o), 1);
        out_en = 1'b0;
        @(negedge clk);
        check(pwm_o == 1'b0, "R9 output low after disable", int'(pwm_o), 0);
        put_write(1'b0, 8'hFF);
        @(negedge clk); put_write(1'b1, 8'h03);
        @(negedge clk); end_write();
        @(negedge clk);
        out_en = 1'b1;
        run_period(0, 1'b0, 0, 0, h);
        check(h == 4, "R9 code cleared by disable", h, 4);
        run_period(0, 1'b0, 0, 0, h);
        check(h == 4, "R9 writes while off discarded", h, 4);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        case_reset();
        case_code(0, 0);
        case_code(0, 6);
        case_code(1, 514);
        case_code(2, 100);
        case_code(3, 0);
        case_code(0, 1019);
        case_code(0, 1023);
        case_update_and_lo_only();
        case_order();
        case_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule